// File: doc/BRIEF.md
# Three-Phase Sextant Angle Estimator

This block takes one sample of a balanced three-phase set (signed fixed-point phases A, B and C) and returns an approximate electrical angle. It does not use a Clarke transform or an arctangent. Three strict comparisons between the phases give a 3-bit ordering code. That code selects one of six 60-degree regions, and the region fixes three things: a base angle at the centre of the region, which phase is the middle one, and the sign of the local correction.

Inside a region the middle phase crosses zero. Its magnitude, divided by the spread between the largest and smallest phase, gives a ratio between 0 and 1/3. The ratio is scaled by a quarter turn, which is the linear constant of pi/2 radians. It is then added to or subtracted from the base angle. The result joins up continuously at the region edges. On clean sinusoids the peak error stays near one degree.

A sample is accepted with a valid strobe while the block is idle. A restoring divider works out the ratio one bit per clock. The angle then appears with a one-cycle valid pulse after a fixed latency.

Top module: `sextant_angle_est`

## Requirements
- R1: After reset `busy`, `outValid`, `degenerate` and `angle` are all 0.
- R2: A sample is accepted on a rising clock edge where `inValid` is 1 and `busy` is 0. `busy` is then 1 until the result edge, which is ANGLE_W-2 edges later (14 with defaults). At that edge `outValid` goes to 1 for one cycle and `busy` returns to 0. `angle` only changes at a result edge.
- R3: The ordering code is {A>B, B>C, C>A}, using strict signed comparisons. The codes map as follows, giving region, middle phase and base angle in 16-bit units: 110 → 0, B, 5461; 010 → 1, A, 16384; 011 → 2, C, 27307; 001 → 3, B, 38229; 101 → 4, A, 49152; 100 → 5, C, 60075. Each base is round((2k+1)·2^ANGLE_W/12), where k is the region. When two phases are equal, the strict comparisons still select one of these regions.
- R4: The spread is den = max − min and q = floor(|mid|·2^(ANGLE_W−2)/den). The output is angle = base + q or base − q, taken modulo 2^ANGLE_W. The minus sign is used when (region is odd) XOR (mid is negative).
- R5: When 3·|mid| > den, q is clamped to floor(2^(ANGLE_W−2)/3) = 5461, which is 30 degrees. This keeps the result inside its region.
- R6: When all three phases are equal, the result is angle 0 with `degenerate` = 1. Every other result has `degenerate` = 0.
- R7: A request presented while `busy` is 1 is ignored. It produces no extra result and does not change the result in progress.
- R8: For balanced sinusoidal inputs, the output is within 1.3 degrees (237 units) of the true electrical angle. Zero is defined as the positive peak of phase A, and the angle increases as the phases rotate in the order A, B, C.
- R9: A sum that reaches 2^ANGLE_W wraps, so the positive peak of A gives angle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample request |
| phaseA | input | DATA_W | Phase A sample, signed |
| phaseB | input | DATA_W | Phase B sample, signed |
| phaseC | input | DATA_W | Phase C sample, signed |
| busy | output | 1 | Computation in progress; requests are ignored |
| outValid | output | 1 | One-cycle result strobe |
| angle | output | ANGLE_W | Electrical angle, full scale is one revolution |
| degenerate | output | 1 | Result came from three equal phases |

## Verification
A sweep of balanced sinusoids at 24 angles, offset from the region edges, visits all six regions in both halves of each. It is checked against the exact arithmetic rule and against the true angle, which separates a wrong base or sign from a wrong scale. Hand-made vectors cover the remaining cases. Equal-pair ties and the peak of phase A show whether the comparisons are strict and whether the sum wraps. Near-equal phases force the 30-degree clamp in both directions. All-equal phases expose the degenerate path. A request pulsed in the middle of a computation shows whether busy samples are really dropped.

// File: rtl/sextant_pkg.sv
package sextant_pkg;
  // strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;    // capture operands from the ports
    logic step;    // one restoring-division iteration
    logic finish;  // form and register the angle
  } ctrlStrobes_t;
endpackage

// File: rtl/sextant_ctrl.sv
module sextant_ctrl
  import sextant_pkg::*;
#(
  parameter int QW = 13
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         outValid
);
  localparam int CNT_W = $clog2(QW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QW);

  logic             running;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobes.load   = inValid & ~running;
    strobes.step   = running & (cnt != LAST);
    strobes.finish = running & (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      cnt      <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.finish;
      if (strobes.load) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == LAST) running <= 1'b0;
        else             cnt     <= cnt + 1'b1;
      end
    end
  end

  assign busy = running;
endmodule

// File: rtl/sextant_datapath.sv
module sextant_datapath
  import sextant_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ANGLE_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic signed [DATA_W-1:0]  phaseA,
  input  logic signed [DATA_W-1:0]  phaseB,
  input  logic signed [DATA_W-1:0]  phaseC,
  output logic [ANGLE_W-1:0]        angle,
  output logic                      degenerate
);
  localparam int QW    = ANGLE_W - 3;
  localparam int DEN_W = DATA_W + 1;
  localparam int P_W   = DATA_W + 2;
  localparam logic [ANGLE_W-1:0] QUARTER = ANGLE_W'(1) << (ANGLE_W - 2);
  localparam logic [ANGLE_W-1:0] CLAMP   = QUARTER / 3;

  function automatic logic [ANGLE_W-1:0] centerOf(input int k);
    longint num;
    num = (longint'(2 * k + 1) << ANGLE_W) + 6;
    return ANGLE_W'(num / 12);
  endfunction

  localparam logic [ANGLE_W-1:0] BASE0 = centerOf(0);
  localparam logic [ANGLE_W-1:0] BASE1 = centerOf(1);
  localparam logic [ANGLE_W-1:0] BASE2 = centerOf(2);
  localparam logic [ANGLE_W-1:0] BASE3 = centerOf(3);
  localparam logic [ANGLE_W-1:0] BASE4 = centerOf(4);
  localparam logic [ANGLE_W-1:0] BASE5 = centerOf(5);

  // ordering and operand selection
  logic [2:0]               orderCode, region;
  logic                     flat;
  logic signed [DATA_W-1:0] mid, hi, lo;
  logic signed [DATA_W:0]   spread, midExt;
  logic [DATA_W:0]          midMag;
  logic [DATA_W+2:0]        mag3;
  logic                     clampNow;

  always_comb begin
    orderCode = {phaseA > phaseB, phaseB > phaseC, phaseC > phaseA};
    flat   = 1'b0;
    region = 3'd0;
    mid = phaseB; hi = phaseA; lo = phaseC;
    unique case (orderCode)
      3'b110: begin region = 3'd0; mid = phaseB; hi = phaseA; lo = phaseC; end
      3'b010: begin region = 3'd1; mid = phaseA; hi = phaseB; lo = phaseC; end
      3'b011: begin region = 3'd2; mid = phaseC; hi = phaseB; lo = phaseA; end
      3'b001: begin region = 3'd3; mid = phaseB; hi = phaseC; lo = phaseA; end
      3'b101: begin region = 3'd4; mid = phaseA; hi = phaseC; lo = phaseB; end
      3'b100: begin region = 3'd5; mid = phaseC; hi = phaseA; lo = phaseB; end
      default: begin flat = 1'b1; mid = phaseA; hi = phaseA; lo = phaseA; end
    endcase
    spread   = {hi[DATA_W-1], hi} - {lo[DATA_W-1], lo};
    midExt   = {mid[DATA_W-1], mid};
    midMag   = midExt[DATA_W] ? DEN_W'(-midExt) : DEN_W'(midExt);
    mag3     = {2'b00, midMag} + {1'b0, midMag, 1'b0};
    clampNow = mag3 > {2'b00, spread};
  end

  // operand and divider registers
  logic [P_W-1:0]     remR;
  logic [QW-1:0]      quotR;
  logic [DEN_W-1:0]   denR;
  logic [2:0]         regionR;
  logic               clampR, flatR, negR;
  logic [P_W-1:0]     shifted;
  logic               fits;

  always_comb begin
    shifted = {remR[P_W-2:0], 1'b0};
    fits    = shifted >= {1'b0, denR};
  end

  // result formation
  logic [ANGLE_W-1:0] base, term, sum;

  always_comb begin
    unique case (regionR)
      3'd0:    base = BASE0;
      3'd1:    base = BASE1;
      3'd2:    base = BASE2;
      3'd3:    base = BASE3;
      3'd4:    base = BASE4;
      default: base = BASE5;
    endcase
    if (flatR)       term = '0;
    else if (clampR) term = CLAMP;
    else             term = ANGLE_W'(quotR);
    if (flatR)       sum = '0;
    else if (negR)   sum = base - term;
    else             sum = base + term;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0; quotR <= '0; denR <= '0; regionR <= '0;
      clampR <= 1'b0; flatR <= 1'b0; negR <= 1'b0;
      angle <= '0; degenerate <= 1'b0;
    end else begin
      if (strobes.load) begin
        remR    <= {midMag, 1'b0};
        quotR   <= '0;
        denR    <= DEN_W'(spread);
        regionR <= region;
        clampR  <= clampNow;
        flatR   <= flat;
        negR    <= region[0] ^ mid[DATA_W-1];
      end else if (strobes.step) begin
        remR  <= fits ? shifted - {1'b0, denR} : shifted;
        quotR <= {quotR[QW-2:0], fits};
      end
      if (strobes.finish) begin
        angle      <= sum;
        degenerate <= flatR;
      end
    end
  end
endmodule

// File: rtl/sextant_angle_est.sv
module sextant_angle_est
  import sextant_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ANGLE_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] phaseA,
  input  logic signed [DATA_W-1:0] phaseB,
  input  logic signed [DATA_W-1:0] phaseC,
  output logic                     busy,
  output logic                     outValid,
  output logic [ANGLE_W-1:0]       angle,
  output logic                     degenerate
);
  localparam int QW = ANGLE_W - 3;

  ctrlStrobes_t strobes;

  sextant_ctrl #(.QW(QW)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .busy(busy), .outValid(outValid)
  );

  sextant_datapath #(.DATA_W(DATA_W), .ANGLE_W(ANGLE_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .phaseA(phaseA), .phaseB(phaseB), .phaseC(phaseC),
    .angle(angle), .degenerate(degenerate)
  );
endmodule

// File: rtl/sextant_angle_chk.sv
module sextant_angle_chk #(
  parameter int ANGLE_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               busy,
  input logic               outValid,
  input logic [ANGLE_W-1:0] angle,
  input logic               degenerate
);
  localparam int LAT   = ANGLE_W - 2;
  localparam int CNT_W = $clog2(LAT + 2) + 1;

  logic [CNT_W-1:0] since;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) since <= '0;
    else if (inValid && !busy) since <= '0;
    else if (busy) since <= since + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> since == CNT_W'(LAT));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R2
  idle_at_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);

  // R2
  hold_angle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(angle));

  // R7
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(inValid));

  // R6
  degenerate_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && degenerate) |-> angle == '0);
endmodule

bind sextant_angle_est sextant_angle_chk #(.ANGLE_W(ANGLE_W)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .busy(busy),
  .outValid(outValid), .angle(angle), .degenerate(degenerate)
);

// File: tb/sextant_angle_est_test.sv
module sextant_angle_est_test;
  localparam int DATA_W = 16;
  localparam int ANGLE_W = 16;
  localparam int LAT = ANGLE_W - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] phaseA = '0, phaseB = '0, phaseC = '0;
  logic busy, outValid, degenerate;
  logic [ANGLE_W-1:0] angle;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sextant_angle_est #(.DATA_W(DATA_W), .ANGLE_W(ANGLE_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .phaseA(phaseA), .phaseB(phaseB), .phaseC(phaseC),
    .busy(busy), .outValid(outValid), .angle(angle), .degenerate(degenerate)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference rule from R3..R6
  function automatic void model(input int a, input int b, input int c,
                                output int ang, output int deg);
    int bases[6] = '{5461, 16384, 27307, 38229, 49152, 60075};
    int k, mid, hi, lo, den, mag, q;
    bit neg;
    bit [2:0] code;
    code = {a > b, b > c, c > a};
    deg = 0;
    k = 0; mid = 0; hi = 0; lo = 0;
    case (code)
      3'b110: begin k = 0; mid = b; hi = a; lo = c; end
      3'b010: begin k = 1; mid = a; hi = b; lo = c; end
      3'b011: begin k = 2; mid = c; hi = b; lo = a; end
      3'b001: begin k = 3; mid = b; hi = c; lo = a; end
      3'b101: begin k = 4; mid = a; hi = c; lo = b; end
      3'b100: begin k = 5; mid = c; hi = a; lo = b; end
      default: deg = 1;
    endcase
    if (deg == 1) begin
      ang = 0;
      return;
    end
    den = hi - lo;
    mag = (mid < 0) ? -mid : mid;
    if (3 * mag > den) q = 5461;
    else q = int'((longint'(mag) * 16384) / den);
    neg = (k % 2 == 1) ^ (mid < 0);
    ang = (bases[k] + (neg ? -q : q)) & 16'hFFFF;
  endfunction

  // apply one sample, return angle, degenerate flag and latency seen
  task automatic runSample(input int a, input int b, input int c,
                           output int ang, output int deg, output int lat);
    @(negedge clk);
    phaseA = DATA_W'(a); phaseB = DATA_W'(b); phaseC = DATA_W'(c);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    lat = 0;
    ang = -1; deg = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      lat++;
      if (outValid) begin
        ang = int'(angle);
        deg = int'(degenerate);
        break;
      end
    end
  endtask

  task automatic checkVector(input string req, input int a, input int b, input int c);
    int ang, deg, lat, eAng, eDeg;
    model(a, b, c, eAng, eDeg);
    runSample(a, b, c, ang, deg, lat);
    check(req, ang, eAng);
    check(req, deg, eDeg);
  endtask

  task automatic testReset();
    check("R1 busy", int'(busy), 0);
    check("R1 outValid", int'(outValid), 0);
    check("R1 angle", int'(angle), 0);
    check("R1 degenerate", int'(degenerate), 0);
  endtask

  task automatic testLatency();
    int ang, deg, lat, eAng, eDeg;
    model(300, 100, -400, eAng, eDeg);
    runSample(300, 100, -400, ang, deg, lat);
    check("R2 latency", lat, LAT);
    check("R4 value 7801", ang, 7801);
    @(negedge clk);
    check("R2 pulse ends", int'(outValid), 0);
    check("R2 idle after", int'(busy), 0);
  endtask

  task automatic testSweep();
    real pi = 3.14159265358979;
    for (int i = 0; i < 24; i++) begin
      real th;
      int a, b, c, ang, deg, lat, eAng, eDeg, truth, err;
      th = (15.0 * i + 7.0) * pi / 180.0;
      a = $rtoi($floor(12000.0 * $cos(th) + 0.5));
      b = $rtoi($floor(12000.0 * $cos(th - 2.0 * pi / 3.0) + 0.5));
      c = $rtoi($floor(12000.0 * $cos(th + 2.0 * pi / 3.0) + 0.5));
      model(a, b, c, eAng, eDeg);
      runSample(a, b, c, ang, deg, lat);
      check("R3 R4 sweep exact", ang, eAng);
      truth = $rtoi($floor(th / (2.0 * pi) * 65536.0 + 0.5));
      err = ((ang - truth + 32768 + 65536) % 65536) - 32768;
      if (err < 0) err = -err;
      check("R8 accuracy", int'(err <= 237), 1);
    end
  endtask

  task automatic testTies();
    checkVector("R3 tie A=B", 5000, 5000, -10000);
    checkVector("R3 tie B=C", 10000, -5000, -5000);
    checkVector("R3 tie C=A", -5000, 10000, -5000);
    checkVector("R4 full scale", 32767, -32768, 0);
  endtask

  task automatic testWrap();
    int ang, deg, lat;
    runSample(16000, -8000, -8000, ang, deg, lat);
    check("R9 wrap to zero", ang, 0);
  endtask

  task automatic testClamp();
    int ang, deg, lat;
    runSample(100, 99, 98, ang, deg, lat);
    check("R5 clamp up", ang, 10922);
    runSample(-98, -99, -100, ang, deg, lat);
    check("R5 clamp down", ang, 0);
  endtask

  task automatic testDegenerate();
    int ang, deg, lat;
    runSample(0, 0, 0, ang, deg, lat);
    check("R6 zero angle", ang, 0);
    check("R6 flag", deg, 1);
    runSample(-500, -500, -500, ang, deg, lat);
    check("R6 flag negative", deg, 1);
    runSample(300, 100, -400, ang, deg, lat);
    check("R6 flag clears", deg, 0);
  endtask

  task automatic testIgnore();
    int outs = 0;
    int first = -1;
    @(negedge clk);
    phaseA = 300; phaseB = 100; phaseC = -400;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    phaseA = 0; phaseB = 0; phaseC = 0;
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (outValid) begin
        outs++;
        if (first < 0) first = int'(angle);
      end
    end
    check("R7 single result", outs, 1);
    check("R7 result unchanged", first, 7801);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLatency();
    testSweep();
    testTies();
    testWrap();
    testClamp();
    testDegenerate();
    testIgnore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule